// File: doc/BRIEF.md
# Serial Port FIFO Control With Receive Trigger

This block holds the FIFO control logic of a classic byte-wide serial port. A write-only control byte selects FIFO mode, picks the receive trigger threshold and can flush either queue. The transmit queue is filled by the host and drained by the transmit shifter. The receive queue is filled by the receive deserializer and drained by the host. Each queue exposes a push/pop handshake, a fill count and a full flag.

The receive side raises a data-available request once enough bytes are waiting. In FIFO mode the threshold is one of four non-linear levels. Outside FIFO mode, each queue behaves as a single-byte holding register and the request follows "at least one byte held". A byte pushed into a full receive queue is dropped and reported by a one-cycle overrun pulse.

The flush bits act only in the cycle of the write; nothing of them is stored. A flush empties the queue's storage and counter, but leaves the last byte handed to the shifter (the read data output) untouched.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both counts are 0, FIFO mode is off, `rx_avail`, `rx_overrun`, both full flags and both read data outputs are 0.
- R2: Control bit 0 written as 1 enables FIFO mode, where each queue holds up to 16 bytes. Written as 0, each queue holds at most one byte, and `fifo_mode` shows the bit from the cycle after the write.
- R3: A control write with bit 2 set empties the transmit queue, so `tx_count` is 0 in the next cycle. `tx_rdata` keeps its value, and a transmit push or pop in that same cycle is ignored.
- R4: A control write with bit 1 set empties the receive queue in the same way. `rx_count` is 0 next cycle, `rx_rdata` keeps its value, and a receive push or pop in that cycle is ignored.
- R5: The flush bits are not stored. A later write with bits 1 and 2 at 0 flushes nothing, and pushes in the cycle after a flush are accepted.
- R6: Control bits 7:6 pick the receive trigger: 00 means 1 byte, 01 means 4, 10 means 8, 11 means 14. In FIFO mode `rx_avail` is high exactly when `rx_count` is at or above the selected level.
- R7: Outside FIFO mode `rx_avail` is high exactly when `rx_count` is not 0.
- R8: Control bits 3, 4 and 5 have no effect on any output.
- R9: A push into a full queue is dropped and the count is unchanged. A dropped receive push makes `rx_overrun` high for exactly the next cycle.
- R10: A pop of an empty queue leaves the count at 0 and the read data output unchanged.
- R11: Each queue is first-in first-out. A pop of a non-empty queue puts the oldest byte on the read data output in the next cycle. A push and a pop in the same cycle are both honoured, except that a push into a full queue is dropped.
- R12: A control write with bit 0 at 0 while FIFO mode is on flushes both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Shifter takes a transmit byte |
| tx_rdata | output | 8 | Last transmit byte taken |
| tx_count | output | 5 | Transmit fill level |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_wdata | input | 8 | Received byte in |
| rx_pop | input | 1 | Host reads a received byte |
| rx_rdata | output | 8 | Last received byte read |
| rx_count | output | 5 | Receive fill level |
| rx_full | output | 1 | Receive queue at capacity |
| rx_overrun | output | 1 | One-cycle pulse after a dropped receive byte |
| rx_avail | output | 1 | Receive data available request |
| fifo_mode | output | 1 | FIFO mode enabled |

## Verification
The receive queue is filled byte by byte under each of the four trigger codes. This shows whether the request rises at exactly 1, 4, 8 or 14 and not one byte early or late. Flushes are issued with a same-cycle push and with control bits 3 to 5 set, which separates flush precedence and ignored bits from ordinary traffic. A following write without flush bits shows that nothing was latched. Overfilling and overdraining in both modes separate the 16-byte and single-byte capacities. A long random mix of pushes, pops and control writes, compared every cycle against a queue model, checks ordering and counts.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
    localparam int CTRL_W       = 8;
    localparam int BIT_ENABLE   = 0;
    localparam int BIT_RX_FLUSH = 1;
    localparam int BIT_TX_FLUSH = 2;
    localparam int TRIG_LSB     = 6;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_e;

    function automatic int unsigned trig_bytes(input trig_e code);
        case (code)
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction
endpackage

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic              fifo_en,
    output trig_e             trig,
    output logic              flush_rx,
    output logic              flush_tx
);
    typedef struct packed {
        logic  en;
        trig_e trig;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        flush_rx = 1'b0;
        flush_tx = 1'b0;
        if (we) begin
            flush_rx  = wdata[BIT_RX_FLUSH] | (st_q.en & ~wdata[BIT_ENABLE]);
            flush_tx  = wdata[BIT_TX_FLUSH] | (st_q.en & ~wdata[BIT_ENABLE]);
            st_d.en   = wdata[BIT_ENABLE];
            st_d.trig = trig_e'(wdata[TRIG_LSB +: 2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: 1'b0, trig: TRIG_ONE};
        else        st_q <= st_d;
    end

    assign fifo_en = st_q.en;
    assign trig    = st_q.trig;
endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              din,
    input  logic                       pop,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wr;
        logic [AW-1:0]            rd;
        logic [CW-1:0]            cnt;
        logic [DW-1:0]            dout;
    } fifo_t;

    fifo_t         st_d, st_q;
    logic [CW-1:0] cap;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
    assign full    = (st_q.cnt >= cap);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (pop_ok) begin
                st_d.dout = st_q.mem[st_q.rd];
                st_d.rd   = bump(st_q.rd);
            end
            if (push_ok) begin
                st_d.mem[st_q.wr] = din;
                st_d.wr           = bump(st_q.wr);
            end
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.dout;
    assign count = st_q.cnt;
endmodule

// File: rtl/ufc_trigger.sv
module ufc_trigger
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       fifo_en,
    input  trig_e                      trig,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       avail
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] level;

    always_comb begin
        level = CW'(trig_bytes(trig));
        if (fifo_en) avail = (count >= level);
        else         avail = (count != '0);
    end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              tx_push,
    input  logic [DW-1:0]     tx_wdata,
    input  logic              tx_pop,
    output logic [DW-1:0]     tx_rdata,
    output logic [CW-1:0]     tx_count,
    output logic              tx_full,
    input  logic              rx_push,
    input  logic [DW-1:0]     rx_wdata,
    input  logic              rx_pop,
    output logic [DW-1:0]     rx_rdata,
    output logic [CW-1:0]     rx_count,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              rx_avail,
    output logic              fifo_mode
);
    typedef struct packed {
        logic ovr;
    } top_t;

    logic  en, flush_rx, flush_tx;
    trig_e trig;
    top_t  st_d, st_q;

    ufc_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .fifo_en  (en),
        .trig     (trig),
        .flush_rx (flush_rx),
        .flush_tx (flush_tx)
    );

    ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (en),
        .flush   (flush_tx),
        .push    (tx_push),
        .din     (tx_wdata),
        .pop     (tx_pop),
        .dout    (tx_rdata),
        .count   (tx_count),
        .full    (tx_full)
    );

    ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (en),
        .flush   (flush_rx),
        .push    (rx_push),
        .din     (rx_wdata),
        .pop     (rx_pop),
        .dout    (rx_rdata),
        .count   (rx_count),
        .full    (rx_full)
    );

    ufc_trigger #(.DEPTH(DEPTH)) u_trig (
        .fifo_en (en),
        .trig    (trig),
        .count   (rx_count),
        .avail   (rx_avail)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovr = rx_push & rx_full & ~flush_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_overrun = st_q.ovr;
    assign fifo_mode  = en;
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [7:0]    cfg_wdata,
    input logic [DW-1:0] tx_rdata,
    input logic [CW-1:0] tx_count,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [DW-1:0] rx_rdata,
    input logic [CW-1:0] rx_count,
    input logic          rx_overrun,
    input logic          rx_avail,
    input logic          fifo_mode
);
    // R3
    p_tx_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[2] |=> (tx_count == '0) && $stable(tx_rdata));
    // R4
    p_rx_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[1] |=> (rx_count == '0) && $stable(rx_rdata));
    // R12
    p_disable_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_wdata[0] && fifo_mode |=> (tx_count == '0) && (rx_count == '0));
    // R9
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));
    // R9
    p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> $past(rx_push));
    // R10
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && (rx_count == '0) |=> $stable(rx_rdata) && (rx_count <= 1));
    // R2
    p_single_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> (rx_count <= 1) && (tx_count <= 1));
    // R6
    p_trig_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode && (rx_count >= 14) |-> rx_avail);
    // R6
    p_trig_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_avail);
endmodule

bind uart_fifo_ctl ufc_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .tx_rdata   (tx_rdata),
    .tx_count   (tx_count),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .rx_rdata   (rx_rdata),
    .rx_count   (rx_count),
    .rx_overrun (rx_overrun),
    .rx_avail   (rx_avail),
    .fifo_mode  (fifo_mode)
);

// File: tb/sim_uart_fifo_ctl.sv
module sim_uart_fifo_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0;
    logic [7:0] tx_rdata, rx_rdata;
    logic [4:0] tx_count, rx_count;
    logic       tx_full, rx_full, rx_overrun, rx_avail, fifo_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_full(tx_full),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .rx_avail(rx_avail), .fifo_mode(fifo_mode)
    );

    int    n_chk = 0, n_bad = 0;
    string phase = "R1";

    // behavioural reference model
    int m_en = 0, m_trig = 0, m_txd = 0, m_rxd = 0, m_ovr = 0;
    int txq[$], rxq[$];

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    function automatic int lvl(int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic compare();
        int cap = (m_en != 0) ? DEPTH : 1;
        int av  = (m_en != 0) ? int'(rxq.size() >= lvl(m_trig)) : int'(rxq.size() != 0);
        chk("tx_count R11", int'(tx_count), txq.size());
        chk("rx_count R11", int'(rx_count), rxq.size());
        chk("tx_rdata R11", int'(tx_rdata), m_txd);
        chk("rx_rdata R10", int'(rx_rdata), m_rxd);
        chk("rx_avail R6",  int'(rx_avail), av);
        chk("rx_overrun R9", int'(rx_overrun), m_ovr);
        chk("fifo_mode R2", int'(fifo_mode), m_en);
        chk("tx_full R2", int'(tx_full), int'(txq.size() >= cap));
        chk("rx_full R2", int'(rx_full), int'(rxq.size() >= cap));
    endtask

    task automatic cyc(bit we, int wd, bit tpu, int td, bit tpo,
                       bit rpu, int rd, bit rpo);
        int  cap;
        bit  ftx, frx;
        compare();
        cfg_we = we; cfg_wdata = wd[7:0];
        tx_push = tpu; tx_wdata = td[7:0]; tx_pop = tpo;
        rx_push = rpu; rx_wdata = rd[7:0]; rx_pop = rpo;
        cap = (m_en != 0) ? DEPTH : 1;
        ftx = we && (wd[2] || (m_en != 0 && !wd[0]));
        frx = we && (wd[1] || (m_en != 0 && !wd[0]));
        m_ovr = 0;
        if (ftx) txq.delete();
        else begin
            bit pu = tpu && txq.size() < cap;
            if (tpo && txq.size() > 0) m_txd = txq.pop_front();
            if (pu) txq.push_back(td & 8'hff);
        end
        if (frx) rxq.delete();
        else begin
            bit pu = rpu && rxq.size() < cap;
            if (rpu && !pu) m_ovr = 1;
            if (rpo && rxq.size() > 0) m_rxd = rxq.pop_front();
            if (pu) rxq.push_back(rd & 8'hff);
        end
        if (we) begin
            m_en = wd[0];
            m_trig = (wd >> 6) & 3;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();       cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic wr(int v);    cyc(1, v, 0, 0, 0, 0, 0, 0); endtask
    task automatic rxin(int v);  cyc(0, 0, 0, 0, 0, 1, v, 0); endtask
    task automatic rxout();      cyc(0, 0, 0, 0, 0, 0, 0, 1); endtask
    task automatic txin(int v);  cyc(0, 0, 1, v, 0, 0, 0, 0); endtask
    task automatic txout();      cyc(0, 0, 0, 0, 1, 0, 0, 0); endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        idle();

        // trigger levels, each code filled from empty
        phase = "R6";
        for (int c = 0; c < 4; c++) begin
            wr(1 | (c << 6) | 2);
            for (int i = 0; i < 15; i++) rxin(8'h10 + i);
        end

        phase = "R9";
        rxin(8'hA1);
        rxin(8'hA2);
        idle();

        phase = "R11";
        for (int i = 0; i < 8; i++) rxout();
        for (int i = 0; i < 6; i++) txin(8'h40 + i);
        cyc(0, 0, 1, 8'h77, 1, 1, 8'h55, 1);
        for (int i = 0; i < 4; i++) txout();

        phase = "R10";
        for (int i = 0; i < 12; i++) rxout();
        rxout();
        for (int i = 0; i < 4; i++) txout();

        phase = "R3";
        for (int i = 0; i < 5; i++) txin(8'h60 + i);
        txout();
        cyc(1, 8'h05, 1, 8'h99, 1, 1, 8'h31, 0);
        idle();

        phase = "R5";
        txin(8'h21);
        wr(8'h01);
        txin(8'h22);
        idle();

        phase = "R8";
        for (int i = 0; i < 4; i++) rxin(8'h80 + i);
        wr(8'h39);
        wr(8'h79);
        idle();

        phase = "R4";
        rxout();
        cyc(1, 8'h43, 0, 0, 0, 1, 8'hEE, 1);
        rxin(8'h0F);

        phase = "R12";
        txin(8'h33);
        rxin(8'h34);
        wr(8'h00);
        idle();

        phase = "R2";
        txin(8'hB0);
        txin(8'hB1);
        rxin(8'hC0);
        rxin(8'hC1);
        txout();
        idle();

        phase = "R7";
        wr(8'hC0);
        idle();
        rxout();
        rxout();
        wr(8'h00);

        // random mix, compared every cycle
        phase = "R11";
        wr(8'h81);
        for (int i = 0; i < 3000; i++) begin
            int  r  = int'($urandom_range(0, 99));
            bit  we = (r < 2);
            int  wd = int'($urandom_range(0, 255));
            if (r >= 2 && r < 50) wd = wd | 1;
            cyc(we, wd, ($urandom_range(0, 2) != 0), int'($urandom_range(0, 255)),
                ($urandom_range(0, 2) == 0),
                ($urandom_range(0, 2) != 0), int'($urandom_range(0, 255)),
                ($urandom_range(0, 2) == 0));
            if (!we && m_en == 0 && $urandom_range(0, 30) == 0) wr(8'h01 | (wd & 8'hC0));
        end
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule